// File: doc/BRIEF.md
# Guarded Pin-Function Selector

This block holds the per-pin function-select register for a bank of general-purpose pins, together with eight plain pad-setting registers. Writes to the function-select register are filtered bit by bit through a commit mask. The commit mask can only be rewritten after software has opened a lock with a 32-bit key value. The lock therefore protects pin assignments that must not be changed by accident, such as a debug port. Software can still move any pin that the mask leaves open.

The block sits on a simple 32-bit register bus with a 12-bit byte address and a single-cycle write strobe. Reads are combinational from the address and the stored state. The stored values drive the output ports directly, so pad logic elsewhere in the chip can use them. The block does no pad muxing and has no electrical effect of its own.

Top module: `pin_func_guard`

## Requirements
- R1: After reset the lock register (offset 0x520) reads 1 and the commit mask (offset 0x524) reads 0xFF. The function-select register (offset 0x420) and all eight pad registers read 0, and every output port is 0.
- R2: A write of exactly 0x0ACCE551 to offset 0x520 opens the lock, so the lock register reads 0. A write of any other value closes it, so it reads 1. All 32 data bits are compared, not only the low byte.
- R3: A write to offset 0x524 updates the commit mask only while the lock is open. While the lock is closed the write is dropped and the mask keeps its old value.
- R4: A write to offset 0x420 updates only those function-select bits whose commit-mask bit is 1. All other bits keep their value. With a mask of 0 the write has no effect.
- R5: The pad registers sit at offsets 0x500 (2 mA drive), 0x504 (4 mA drive), 0x508 (8 mA drive), 0x50C (open drain), 0x510 (pull-up), 0x514 (pull-down), 0x518 (slew control) and 0x51C (digital enable). Each one is freely written and read back on its low 8 bits, and each drives its own output port.
- R6: An open lock stays open through commit-mask writes and other register writes. It closes only when a non-key value is written to offset 0x520.
- R7: A read of any unmapped or misaligned offset returns 0. A write to such an offset changes no register and no output.
- R8: Write data bits above bit 7 are ignored by every 8-bit register. A written value is visible on rdata and on the output ports from the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 12 | Byte offset for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| func_sel_o | output | 8 | Per-pin function select |
| drv2_o | output | 8 | 2 mA drive enables |
| drv4_o | output | 8 | 4 mA drive enables |
| drv8_o | output | 8 | 8 mA drive enables |
| odrain_o | output | 8 | Open-drain enables |
| pullup_o | output | 8 | Pull-up enables |
| pulldn_o | output | 8 | Pull-down enables |
| slew_o | output | 8 | Slew control |
| dig_en_o | output | 8 | Digital input enables |

## Verification
A wrong lock state is not visible on func_sel_o right away. It first shows when a commit write lands or fails to land, and it shows on the function select only at the next function-select write. For this reason the bench reads the lock and mask registers back in the cycle after each change. A bad mask bit shows up on func_sel_o one edge after the next function-select write that covers that bit. Pad registers have no hidden state, so any fault there shows on their port one edge after the write.

// File: rtl/pin_func_guard.sv
module pin_func_guard #(
  parameter int          PINS   = 8,
  parameter int          ADDR_W = 12,
  parameter int          DATA_W = 32,
  parameter logic [31:0] KEY    = 32'h0ACCE551
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [PINS-1:0]   func_sel_o,
  output logic [PINS-1:0]   drv2_o,
  output logic [PINS-1:0]   drv4_o,
  output logic [PINS-1:0]   drv8_o,
  output logic [PINS-1:0]   odrain_o,
  output logic [PINS-1:0]   pullup_o,
  output logic [PINS-1:0]   pulldn_o,
  output logic [PINS-1:0]   slew_o,
  output logic [PINS-1:0]   dig_en_o
);

  localparam int          NPAD       = 8;
  localparam logic [ADDR_W-1:0] OFF_FUNC   = ADDR_W'(12'h420);
  localparam logic [ADDR_W-1:0] OFF_PAD0   = ADDR_W'(12'h500);
  localparam logic [ADDR_W-1:0] OFF_LOCK   = ADDR_W'(12'h520);
  localparam logic [ADDR_W-1:0] OFF_COMMIT = ADDR_W'(12'h524);

  logic            locked_q;
  logic [PINS-1:0] commit_q;
  logic [PINS-1:0] func_q;
  logic [PINS-1:0] pad_q [NPAD];
  logic [NPAD-1:0] pad_hit;
  logic [PINS-1:0] wbyte;

  wire hit_func   = bus_wr && (bus_addr == OFF_FUNC);
  wire hit_lock   = bus_wr && (bus_addr == OFF_LOCK);
  wire hit_commit = bus_wr && (bus_addr == OFF_COMMIT);
  wire key_match  = (bus_wdata == DATA_W'(KEY));

  assign wbyte = bus_wdata[PINS-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        locked_q <= 1'b1;
    else if (hit_lock) locked_q <= !key_match;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       commit_q <= '1;
    else if (hit_commit && !locked_q) commit_q <= wbyte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        func_q <= '0;
    else if (hit_func) func_q <= (func_q & ~commit_q) | (wbyte & commit_q);
  end

  a_r2_key_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_lock && key_match) |=> !locked_q);
  a_r2_other_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_lock && !key_match) |=> locked_q);
  a_r6_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_lock |=> $stable(locked_q));
  a_r3_commit_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_commit && locked_q) |=> $stable(commit_q));
  a_r4_masked_change: assert property (@(posedge clk) disable iff (!rst_n)
    hit_func |=> ((func_q ^ $past(func_q)) & ~$past(commit_q)) == '0);
  a_r7_func_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_func |=> $stable(func_q));

  for (genvar i = 0; i < NPAD; i++) begin : g_pad
    assign pad_hit[i] = bus_wr && (bus_addr == OFF_PAD0 + ADDR_W'(4 * i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pad_q[i] <= '0;
      else if (pad_hit[i]) pad_q[i] <= wbyte;
    end

    a_r5_pad_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !pad_hit[i] |=> $stable(pad_q[i]));
    a_r5_pad_take: assert property (@(posedge clk) disable iff (!rst_n)
      pad_hit[i] |=> pad_q[i] == $past(wbyte));
  end

  a_r4_one_pad_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pad_hit));

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFF_FUNC)   bus_rdata = DATA_W'(func_q);
    if (bus_addr == OFF_LOCK)   bus_rdata = DATA_W'(locked_q);
    if (bus_addr == OFF_COMMIT) bus_rdata = DATA_W'(commit_q);
    for (int i = 0; i < NPAD; i++)
      if (bus_addr == OFF_PAD0 + ADDR_W'(4 * i)) bus_rdata = DATA_W'(pad_q[i]);
  end

  assign func_sel_o = func_q;
  assign drv2_o     = pad_q[0];
  assign drv4_o     = pad_q[1];
  assign drv8_o     = pad_q[2];
  assign odrain_o   = pad_q[3];
  assign pullup_o   = pad_q[4];
  assign pulldn_o   = pad_q[5];
  assign slew_o     = pad_q[6];
  assign dig_en_o   = pad_q[7];

endmodule

// File: tb/pin_func_guard_tb_top.sv
module pin_func_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  func_sel_o, drv2_o, drv4_o, drv8_o, odrain_o, pullup_o, pulldn_o, slew_o, dig_en_o;

  always #10 clk = ~clk;

  pin_func_guard dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .func_sel_o(func_sel_o),
    .drv2_o(drv2_o), .drv4_o(drv4_o), .drv8_o(drv8_o), .odrain_o(odrain_o),
    .pullup_o(pullup_o), .pulldn_o(pulldn_o), .slew_o(slew_o), .dig_en_o(dig_en_o)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  bit m_locked = 1;
  int m_commit = 255;
  int m_func = 0;
  int m_pad[8] = '{default: 0};

  function automatic int pad_index(input int a);
    if (a >= 'h500 && a <= 'h51C && (a % 4) == 0) return (a - 'h500) / 4;
    return -1;
  endfunction

  function automatic int exp_read(input int a);
    if (a == 'h420) return m_func;
    if (a == 'h520) return m_locked ? 1 : 0;
    if (a == 'h524) return m_commit;
    if (pad_index(a) >= 0) return m_pad[pad_index(a)];
    return 0;
  endfunction

  function automatic void model_write(input int a, input logic [31:0] d);
    int b = int'(d[7:0]);
    if (a == 'h520) m_locked = (d != 32'h0ACCE551);
    if (a == 'h524 && !m_locked) m_commit = b;
    if (a == 'h420) m_func = ((m_func & ~m_commit) | (b & m_commit)) & 255;
    if (pad_index(a) >= 0) m_pad[pad_index(a)] = b;
  endfunction

  task automatic cmp(input string tag, input string what, input int act, input int exp, inout bit bad);
    if (act != exp) begin
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      bad = 1;
    end
  endtask

  task automatic check(input string tag);
    bit bad = 0;
    vectors++;
    cmp(tag, "rdata", int'(bus_rdata), exp_read(int'(bus_addr)), bad);
    cmp(tag, "func_sel_o", int'(func_sel_o), m_func, bad);
    cmp(tag, "drv2_o", int'(drv2_o), m_pad[0], bad);
    cmp(tag, "drv4_o", int'(drv4_o), m_pad[1], bad);
    cmp(tag, "drv8_o", int'(drv8_o), m_pad[2], bad);
    cmp(tag, "odrain_o", int'(odrain_o), m_pad[3], bad);
    cmp(tag, "pullup_o", int'(pullup_o), m_pad[4], bad);
    cmp(tag, "pulldn_o", int'(pulldn_o), m_pad[5], bad);
    cmp(tag, "slew_o", int'(slew_o), m_pad[6], bad);
    cmp(tag, "dig_en_o", int'(dig_en_o), m_pad[7], bad);
    if (bad) miscompares++;
  endtask

  task automatic step(input bit wr, input int a, input logic [31:0] d, input string tag);
    @(negedge clk);
    bus_wr = wr; bus_addr = 12'(a); bus_wdata = d;
    #1 check(tag);
    @(posedge clk);
    #1 if (wr) model_write(a, d);
  endtask

  task automatic rd(input int a, input string tag);
    step(0, a, 32'h0, tag);
  endtask

  task automatic wr(input int a, input logic [31:0] d, input string tag);
    step(1, a, d, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    rd('h520, "R1"); rd('h524, "R1"); rd('h420, "R1");
    for (int i = 0; i < 8; i++) rd('h500 + 4 * i, "R1");
    // R4 full mask after reset
    wr('h420, 32'h0000_00A5, "R4"); rd('h420, "R4");
    // R3 commit dropped while closed
    wr('h524, 32'h0000_000F, "R3"); rd('h524, "R3");
    // R2 key handling, full 32-bit compare
    wr('h520, 32'h0ACC_E551, "R2"); rd('h520, "R2");
    wr('h520, 32'h1ACC_E551, "R2"); rd('h520, "R2");
    wr('h520, 32'h0ACC_E551, "R2"); rd('h520, "R2");
    wr('h520, 32'h0000_0051, "R2"); rd('h520, "R2");
    wr('h520, 32'h0ACC_E551, "R2");
    // R3 commit accepted while open, R6 lock stays open
    wr('h524, 32'h0000_000F, "R3"); rd('h524, "R3"); rd('h520, "R6");
    wr('h510, 32'h0000_0003, "R6"); rd('h520, "R6");
    // R4 masked function-select write
    wr('h420, 32'h0000_005A, "R4"); rd('h420, "R4");
    wr('h420, 32'hFFFF_FF00, "R4"); rd('h420, "R4");
    // R3 close then commit dropped
    wr('h520, 32'h0, "R3"); wr('h524, 32'h0000_0033, "R3"); rd('h524, "R3");
    // R4 zero mask freezes function select
    wr('h520, 32'h0ACC_E551, "R4"); wr('h524, 32'h0, "R4");
    wr('h420, 32'h0000_00FF, "R4"); rd('h420, "R4");
    wr('h524, 32'h0000_00C3, "R4"); wr('h420, 32'h0000_003C, "R4"); rd('h420, "R4");
    // R5 and R8 pad registers, upper data bits ignored
    for (int i = 0; i < 8; i++) wr('h500 + 4 * i, 32'hABCD_0000 | (32'h11 * (i + 1)), "R5");
    for (int i = 0; i < 8; i++) rd('h500 + 4 * i, "R8");
    wr('h514, 32'h0000_0000, "R5"); rd('h514, "R5");
    // R7 unmapped and misaligned offsets
    wr('h600, 32'hFFFF_FFFF, "R7"); rd('h600, "R7");
    wr('h502, 32'hFFFF_FFFF, "R7"); rd('h502, "R7");
    wr('h41C, 32'hFFFF_FFFF, "R7"); rd('h41C, "R7"); rd('h522, "R7"); rd('h420, "R7");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule